// File: doc/BRIEF.md
# SPI Transmit Engine with Paced DMA Request

This block is the transmit side of an SPI master. Software, or a DMA engine, writes characters into a data register. Behind that register sits a one-entry staging slot and an 8-bit shift register. The block drives the serial clock, the data line and an active-low chip select. It raises a single-cycle DMA request each time a character moves into the shift register. A DMA channel that is triggered by this request therefore moves exactly one character per request, and the memory-to-SPI stream runs at the serial rate instead of at the memory read rate.

Two enable bits control the request stream: an SPI enable and a DMA request enable. The first request, which starts the DMA chain, comes from the order in which these two bits are set. Setting either bit while the other is already set produces one pulse. If the two bits are set in the same write cycle, neither was already set, so no pulse is produced.

Top module: `spi_tx_dma`

## Requirements
- R1: After reset, sclk is 0, cs_n is 1, mosi is 0 and dma_req is 0.
- R2: Each character is 8 bits, sent MSB first in SPI mode 0: sclk idles low, mosi is stable at every rising sclk edge and changes only after a falling edge. Each sclk half-period lasts div+1 clock cycles, so one isolated character holds cs_n low for 16*(div+1) cycles. cs_n stays low between characters when the next one is ready at the end of the current one.
- R3: Register addresses are: 0 = global control, with SPI enable in bit 24; 1 = interrupt control, with DMA request enable in bit 16; 2 = data, with the character in bits 7:0; 3 = divider, in bits 7:0.
- R4: While DMA request enable is 1, dma_req pulses for exactly one cycle for each character copied into the shift register, whether the copy comes from the staging slot or directly from the data register.
- R5: While DMA request enable is 0, copies into the shift register produce no dma_req pulse.
- R6: Writing DMA request enable from 0 to 1 while SPI enable is already 1 produces exactly one dma_req pulse.
- R7: Writing SPI enable from 0 to 1 while DMA request enable is already 1 produces exactly one dma_req pulse.
- R8: A data write while both the staging slot and the data register hold characters replaces the pending character in the data register. The characters already ahead of it are sent unchanged.
- R9: While SPI enable is 0, the following hold: shifting stops, with cs_n high and sclk low; the staging slot and data register are emptied; data writes are dropped; no dma_req pulse is produced.
- R10: Characters leave in the order in which they were accepted. The staging slot always empties ahead of the data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Register write data |
| sclk | output | 1 | Serial clock (mode 0) |
| mosi | output | 1 | Serial data out, MSB first |
| cs_n | output | 1 | Active-low chip select |
| dma_req | output | 1 | One-cycle transmit DMA request |

## Verification
The hardest case to reach is the overwrite. It requires the shift register to be busy, the staging slot to be full and the data register to be full, all at once. The stimulus writes four characters two cycles apart, with the divider set so that one character lasts 32 cycles. The fourth write then lands while the first character is still shifting out. The serial scoreboard expects the first, second and fourth characters only.

The abort case disables SPI partway through a character and writes data while the block is disabled. After re-enabling, the stimulus watches for a silent chip select and for no extra requests.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
    typedef enum logic [1:0] {
        SEL_GCTL = 2'd0,
        SEL_ICTL = 2'd1,
        SEL_DATA = 2'd2,
        SEL_DIV  = 2'd3
    } reg_sel_e;

    localparam int unsigned SPI_EN_POS  = 24;
    localparam int unsigned DMA_EN_POS  = 16;
endpackage

// File: rtl/spi_tx_ctrl.sv
module spi_tx_ctrl
    import spi_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              spi_en,
    output logic              dma_en,
    output logic [DIV_W-1:0]  div,
    output logic              data_wr,
    output logic              dma_req
);
    typedef struct packed {
        logic             en;
        logic             den;
        logic [DIV_W-1:0] div;
        logic             req;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  first_req;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_GCTL: ctl_d.en  = wr_data[SPI_EN_POS];
                SEL_ICTL: ctl_d.den = wr_data[DMA_EN_POS];
                SEL_DIV:  ctl_d.div = wr_data[DIV_W-1:0];
                default:  ;
            endcase
        end
        // a start pulse comes from whichever enable arrives second
        first_req = (ctl_d.den && !ctl_q.den && ctl_q.en) ||
                    (ctl_d.en  && !ctl_q.en  && ctl_q.den);
        ctl_d.req = first_req || (take && ctl_d.den);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign spi_en  = ctl_q.en;
    assign dma_en  = ctl_q.den;
    assign div     = ctl_q.div;
    assign dma_req = ctl_q.req;
    assign data_wr = wr_en && (reg_sel_e'(wr_addr) == SEL_DATA) && ctl_q.en;

    p_req_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> dma_en);
    p_first_den_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dma_en) && $past(spi_en)) |-> dma_req);
    p_first_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(spi_en) && $past(dma_en)) |-> dma_req);
endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [CHAR_W-1:0] wdata,
    input  logic              take,
    output logic              avail,
    output logic [CHAR_W-1:0] char_out
);
    typedef struct packed {
        logic [CHAR_W-1:0] dat;
        logic [CHAR_W-1:0] stg;
        logic              dat_v;
        logic              stg_v;
    } hold_t;

    hold_t hld_d, hld_q;

    always_comb begin
        hld_d = hld_q;
        if (take) begin
            if (hld_q.stg_v) begin
                hld_d.stg   = hld_q.dat;
                hld_d.stg_v = hld_q.dat_v;
            end
            hld_d.dat_v = 1'b0;
        end else if (hld_q.dat_v && !hld_q.stg_v) begin
            hld_d.stg   = hld_q.dat;
            hld_d.stg_v = 1'b1;
            hld_d.dat_v = 1'b0;
        end
        if (wr) begin
            hld_d.dat   = wdata;
            hld_d.dat_v = 1'b1;
        end
        if (!en) begin
            hld_d.dat_v = 1'b0;
            hld_d.stg_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hld_q <= '0;
        else        hld_q <= hld_d;
    end

    assign avail    = hld_q.stg_v || hld_q.dat_v;
    assign char_out = hld_q.stg_v ? hld_q.stg : hld_q.dat;

    p_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && en && !take && hld_q.dat_v && hld_q.stg_v)
            |=> (hld_q.dat == $past(wdata)) && hld_q.stg_v);
    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !avail);
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  logic              avail,
    input  logic [CHAR_W-1:0] char_in,
    output logic              take,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);
    localparam int unsigned BIT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAR_W - 1);

    typedef struct packed {
        logic [CHAR_W-1:0] sh;
        logic [BIT_W-1:0]  bitn;
        logic [DIV_W-1:0]  cnt;
        logic              busy;
        logic              sclk;
        logic              cs_n;
    } shift_t;

    shift_t sh_d, sh_q;
    logic   tick, last_fall;

    always_comb begin
        tick      = (sh_q.cnt == div);
        last_fall = sh_q.busy && tick && sh_q.sclk && (sh_q.bitn == LAST_BIT);
        take      = en && avail && (!sh_q.busy || last_fall);

        sh_d = sh_q;
        if (sh_q.busy) begin
            sh_d.cnt = tick ? '0 : sh_q.cnt + 1'b1;
            if (tick) begin
                sh_d.sclk = !sh_q.sclk;
                if (sh_q.sclk) begin
                    if (sh_q.bitn == LAST_BIT) begin
                        sh_d.busy = 1'b0;
                        sh_d.cs_n = 1'b1;
                        sh_d.sh   = '0;
                    end else begin
                        sh_d.bitn = sh_q.bitn + 1'b1;
                        sh_d.sh   = {sh_q.sh[CHAR_W-2:0], 1'b0};
                    end
                end
            end
        end
        if (take) begin
            sh_d.sh   = char_in;
            sh_d.bitn = '0;
            sh_d.cnt  = '0;
            sh_d.busy = 1'b1;
            sh_d.sclk = 1'b0;
            sh_d.cs_n = 1'b0;
        end
        if (!en) begin
            sh_d.sh   = '0;
            sh_d.cnt  = '0;
            sh_d.busy = 1'b0;
            sh_d.sclk = 1'b0;
            sh_d.cs_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_q.cs_n <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sclk = sh_q.sclk;
    assign cs_n = sh_q.cs_n;
    assign mosi = sh_q.sh[CHAR_W-1];

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cs_n && !sclk));
    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
    p_sclk_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);
endmodule

// File: rtl/spi_tx_dma.sv
module spi_tx_dma #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              dma_req
);
    logic              spi_en, dma_en, data_wr, take, avail;
    logic [DIV_W-1:0]  div;
    logic [CHAR_W-1:0] next_char;

    spi_tx_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .take(take), .spi_en(spi_en), .dma_en(dma_en),
        .div(div), .data_wr(data_wr), .dma_req(dma_req)
    );

    spi_tx_hold #(.CHAR_W(CHAR_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .en(spi_en), .wr(data_wr),
        .wdata(wr_data[CHAR_W-1:0]), .take(take), .avail(avail),
        .char_out(next_char)
    );

    spi_tx_shift #(.CHAR_W(CHAR_W), .DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(spi_en), .div(div), .avail(avail),
        .char_in(next_char), .take(take), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    p_no_req_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_en && !$past(spi_en)) |-> !dma_req);
endmodule

// File: tb/test_spi_tx_dma.sv
module test_spi_tx_dma;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        sclk, mosi, cs_n, dma_req;

    spi_tx_dma i_spi_tx_dma (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .dma_req(dma_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int dma_cnt  = 0;
    int cs_low   = 0;
    int cs_rise  = 0;
    int rx_bits  = 0;
    logic [7:0] rx_sh = '0;
    logic [7:0] exp_q[$];
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitors
    always @(negedge clk) begin
        if (rst_n && dma_req) dma_cnt++;
        if (rst_n && !cs_n)   cs_low++;
    end

    always @(posedge cs_n) begin
        if (rst_n) cs_rise++;
        rx_bits = 0;
    end

    always @(posedge sclk) begin
        rx_sh = {rx_sh[6:0], mosi};
        rx_bits++;
        if (rx_bits == 8) begin
            rx_bits = 0;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected char", int'(rx_sh), -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_sh == e, "R2/R8/R10 serial char", int'(rx_sh), int'(e));
            end
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] c, input bit expect_out);
        if (expect_out) exp_q.push_back(c);
        reg_wr(2'd2, {24'd0, c});
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_up();
        end
    end

    initial begin
        int p0, c0, r0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);
        // R1 reset state
        check(sclk == 0, "R1 sclk", sclk, 0);
        check(cs_n == 1, "R1 cs_n", cs_n, 1);
        check(mosi == 0, "R1 mosi", mosi, 0);
        check(dma_req == 0, "R1 dma_req", dma_req, 0);
        dma_cnt = 0; cs_rise = 0; cs_low = 0;

        // R3 divider and SPI enable, then R6 first request
        reg_wr(2'd3, 32'd1);
        p0 = dma_cnt;
        reg_wr(2'd0, 32'h0100_0000);
        wait_clk(5);
        check(dma_cnt == p0, "R6 no pulse from SPI enable alone", dma_cnt - p0, 0);
        reg_wr(2'd1, 32'h0001_0000);
        wait_clk(5);
        check(dma_cnt - p0 == 1, "R6 first request", dma_cnt - p0, 1);

        // R4 one pulse per copy, R2 back-to-back frame, R10 order
        p0 = dma_cnt; r0 = cs_rise;
        send(8'hA5, 1); send(8'h3C, 1); send(8'hF0, 1);
        wait_clk(130);
        check(dma_cnt - p0 == 3, "R4 pulses per copy", dma_cnt - p0, 3);
        check(cs_rise - r0 == 1, "R2 continuous frame", cs_rise - r0, 1);
        check(exp_q.size() == 0, "R10 all chars out", exp_q.size(), 0);

        // R5 requests off; R2 frame length 16*(div+1)
        reg_wr(2'd1, 32'h0);
        p0 = dma_cnt; c0 = cs_low;
        send(8'h96, 1);
        wait_clk(60);
        check(cs_low - c0 == 32, "R2 frame length", cs_low - c0, 32);
        send(8'h01, 1); send(8'h80, 1);
        wait_clk(100);
        check(dma_cnt == p0, "R5 no pulses when disabled", dma_cnt - p0, 0);

        // R8 overwrite of pending character
        send(8'h11, 1); send(8'h22, 1); send(8'h33, 0); send(8'h44, 1);
        wait_clk(150);
        check(exp_q.size() == 0, "R8 overwrite result", exp_q.size(), 0);

        // R7 first request from SPI enable
        reg_wr(2'd0, 32'h0);
        p0 = dma_cnt;
        reg_wr(2'd1, 32'h0001_0000);
        wait_clk(5);
        check(dma_cnt == p0, "R9 no pulse while SPI off", dma_cnt - p0, 0);
        reg_wr(2'd0, 32'h0100_0000);
        wait_clk(5);
        check(dma_cnt - p0 == 1, "R7 first request", dma_cnt - p0, 1);

        // R9 abort mid-character, drop writes while off
        p0 = dma_cnt;
        send(8'h5A, 0);
        wait_clk(10);
        reg_wr(2'd0, 32'h0);
        wait_clk(1);
        check(cs_n == 1, "R9 cs_n after disable", cs_n, 1);
        check(sclk == 0, "R9 sclk after disable", sclk, 0);
        send(8'h77, 0);
        reg_wr(2'd1, 32'h0);
        c0 = cs_low;
        reg_wr(2'd0, 32'h0100_0000);
        wait_clk(80);
        check(cs_low == c0, "R9 nothing sent after flush", cs_low - c0, 0);
        check(dma_cnt - p0 == 1, "R9 requests after abort", dma_cnt - p0, 1);
        send(8'h81, 1);
        wait_clk(60);
        check(exp_q.size() == 0, "R9 resumes cleanly", exp_q.size(), 0);

        done = 1'b1;
        finish_up();
    end
endmodule